// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight interrupt inputs and turns them into one request line to the processor. Requests are latched on rising edges. A mask can block each input. Priority is fixed, with input 0 the most urgent, and nesting is full: an input gets through only while no equal or more urgent level is in service. Software drives the block through a byte-wide register port that has two addresses. The even address takes command bytes and returns status. The odd address carries the initialization words and, once they have been taken, the interrupt mask.

Two instances can be cascaded to serve sixteen sources. One is built as the master. The other is a slave whose interrupt output feeds one of the master's inputs. When the processor acknowledges, the master either supplies the vector itself or drives the three-bit identity of a slave on the cascade lines. The slave with that identity then supplies the vector. Software can also work without the acknowledge strobe. A poll command makes the next status read return the most urgent pending level and acknowledge it.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF at the odd address, the even address returns the request register (0x00), and `int_out` is low.
- R2: An even-address write with bit 4 set starts initialization. It clears the mask, in-service and request registers and selects the request register for even reads. The next three odd writes are taken in turn as the vector base (bits 7:3 kept), the cascade word and, only if bit 0 of the start byte was set, the mode word. After that, odd writes and reads access the mask.
- R3: A mask bit set to 1 stops the matching input from raising `int_out` or being acknowledged. The mask read returns the value last written.
- R4: Request bit i sets on a rising edge of input i. It clears when that level is acknowledged, or when input i goes low again before acknowledge.
- R5: `int_out` is high exactly when some unmasked request has a lower index than every set in-service bit (or no in-service bit is set), and initialization is complete.
- R6: An even write of 0x20 clears the lowest-index set bit of the in-service register.
- R7: An even write of 0x0B makes even reads return the in-service register. An even write of 0x0A makes them return the request register.
- R8: After an even write of 0x0C, the next even read returns 0x80 plus the level of the most urgent pending request, sets that in-service bit and clears that request bit. With nothing pending it returns 0x07 and leaves the in-service register unchanged. Later reads return the selected register again.
- R9: While `ack` is high, a controller that supplies the vector drives `vec_valid` high, with `vec_out` equal to the vector base in bits 7:3 and the level in bits 2:0. It then sets that level's in-service bit. If no request is pending, the level is 7 and no in-service bit is set.
- R10: When the master acknowledges a level whose cascade-word bit is set, it drives that level on `cas_out`, keeps `vec_valid` low and sets that in-service bit. A slave supplies the vector only when `cas_in` equals bits 2:0 of its cascade word. Otherwise `cas_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| rd_en | input | 1 | Register read strobe, one cycle per read |
| addr | input | 1 | Register address: 0 even, 1 odd |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, valid while rd_en is high |
| irq_in | input | 8 | Interrupt inputs, index 0 most urgent |
| int_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Interrupt acknowledge strobe, one cycle |
| cas_in | input | 3 | Cascade identity seen by a slave |
| cas_out | output | 3 | Cascade identity driven by a master on acknowledge |
| vec_valid | output | 1 | This controller supplies the vector during ack |
| vec_out | output | 8 | Vector byte |

## Verification
The assertions assume that a read, a write and an acknowledge never fall in the same cycle. They also assume that each strobe lasts one cycle and that inputs change only between clock edges. The bench drives every strobe from tasks that raise a single signal for one cycle at the falling edge. Interrupt inputs are changed only while no strobe is active. Random rounds pick a mask and an input pattern, but they leave the cascaded input to the slave, so the master never acknowledges a cascade level by accident.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int NUM_IN = 8;
    localparam int LVL_W  = $clog2(NUM_IN);
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_BASE,
        ST_CASC,
        ST_MODE
    } init_st_e;

    typedef struct packed {
        init_st_e                 st;
        logic [NUM_IN-1:0]        imr;
        logic [NUM_IN-1:0]        isr;
        logic [NUM_IN-1:0]        irr;
        logic [DATA_W-LVL_W-1:0]  base;
        logic [DATA_W-1:0]        casc;
        logic                     want_mode;
        logic                     rd_isr;
        logic                     poll;
    } ctrl_t;

endpackage

// File: rtl/irq_edge_cap.sv
module irq_edge_cap #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_in,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign rise[i] = lvl_in[i] & ~prev_q[i];
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter bit IS_MASTER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NUM_IN-1:0] irq_in,
    output logic              int_out,
    input  logic              ack,
    input  logic [LVL_W-1:0]  cas_in,
    output logic [LVL_W-1:0]  cas_out,
    output logic              vec_valid,
    output logic [DATA_W-1:0] vec_out
);
    ctrl_t d, q;

    logic [NUM_IN-1:0] rise;
    logic              req_found, isr_found;
    logic [LVL_W-1:0]  req_idx, isr_idx, lvl;
    logic              pend, running, casc_hit, take;

    irq_edge_cap #(.N(NUM_IN)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_in (irq_in),
        .rise   (rise)
    );

    irq_prio_pick #(.N(NUM_IN), .W(LVL_W)) u_pick_req (
        .req   (q.irr & ~q.imr),
        .found (req_found),
        .idx   (req_idx)
    );

    irq_prio_pick #(.N(NUM_IN), .W(LVL_W)) u_pick_isr (
        .req   (q.isr),
        .found (isr_found),
        .idx   (isr_idx)
    );

    assign running  = (q.st == ST_RUN);
    assign pend     = req_found && (!isr_found || (req_idx < isr_idx));
    assign lvl      = pend ? req_idx : '1;
    assign casc_hit = IS_MASTER && pend && q.casc[lvl];
    assign take     = ack && running && (IS_MASTER || (cas_in == q.casc[LVL_W-1:0]));

    assign int_out   = pend && running;
    assign cas_out   = (take && casc_hit) ? lvl : '0;
    assign vec_valid = take && !casc_hit;
    assign vec_out   = {q.base, lvl};

    always_comb begin
        if (addr)        rdata = q.imr;
        else if (q.poll) rdata = {pend, {(DATA_W-LVL_W-1){1'b0}}, lvl};
        else if (q.rd_isr) rdata = q.isr;
        else             rdata = q.irr;
    end

    always_comb begin
        d = q;
        // requests latch on a rise and hold only while the input stays high
        d.irr = (q.irr | rise) & irq_in;

        if (take && pend) begin
            d.isr[lvl] = 1'b1;
            d.irr[lvl] = 1'b0;
        end

        if (rd_en && !addr && q.poll && running) begin
            d.poll = 1'b0;
            if (pend) begin
                d.isr[lvl] = 1'b1;
                d.irr[lvl] = 1'b0;
            end
        end

        if (wr_en) begin
            if (!addr) begin
                if (wdata[4]) begin
                    d.st        = ST_BASE;
                    d.want_mode = wdata[0];
                    d.imr       = '0;
                    d.isr       = '0;
                    d.irr       = '0;
                    d.rd_isr    = 1'b0;
                    d.poll      = 1'b0;
                end else if (running) begin
                    if (!wdata[3]) begin
                        if (wdata[7:5] == 3'b001 && isr_found) d.isr[isr_idx] = 1'b0;
                    end else begin
                        d.poll = wdata[2];
                        if (wdata[1]) d.rd_isr = wdata[0];
                    end
                end
            end else begin
                case (q.st)
                    ST_BASE: begin
                        d.base = wdata[DATA_W-1:LVL_W];
                        d.st   = ST_CASC;
                    end
                    ST_CASC: begin
                        d.casc = wdata;
                        d.st   = q.want_mode ? ST_MODE : ST_RUN;
                    end
                    ST_MODE: d.st = ST_RUN;
                    default: d.imr = wdata;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st        <= ST_RUN;
            q.imr       <= '1;
            q.isr       <= '0;
            q.irr       <= '0;
            q.base      <= '0;
            q.casc      <= '0;
            q.want_mode <= 1'b0;
            q.rd_isr    <= 1'b0;
            q.poll      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    // R2
    init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4]) |=> (q.imr == '0 && q.isr == '0 && q.irr == '0));

    // R4
    req_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q.irr & ~$past(irq_in)) == '0));

    // R5
    int_has_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> (|(q.irr & ~q.imr)));

    // R6
    eoi_clears_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata == 8'h20 && running && (|q.isr) && !ack && !rd_en)
        |=> ($countones(q.isr) == $countones($past(q.isr)) - 1));

    // R9
    spurious_no_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !pend && !wr_en && !rd_en) |=> (q.isr == $past(q.isr)));

    // R10
    cascade_no_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && (cas_out != '0)) |-> !vec_valid);
endmodule

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic       m_we = 0, m_re = 0, m_a = 0;
    logic [7:0] m_wd = 0, m_rd;
    logic       s_we = 0, s_re = 0, s_a = 0;
    logic [7:0] s_wd = 0, s_rd;
    logic [7:0] m_src = 0, s_src = 0;
    logic       ack = 0;
    logic       m_int, s_int, m_vv, s_vv;
    logic [2:0] m_cas, s_cas;
    logic [7:0] m_vec, s_vec, m_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    assign m_irq = {m_src[7:3], s_int, m_src[1:0]};

    irq_prio_ctrl #(.IS_MASTER(1'b1)) i_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(m_we), .rd_en(m_re), .addr(m_a),
        .wdata(m_wd), .rdata(m_rd), .irq_in(m_irq), .int_out(m_int),
        .ack(ack), .cas_in(3'd0), .cas_out(m_cas), .vec_valid(m_vv), .vec_out(m_vec)
    );

    irq_prio_ctrl #(.IS_MASTER(1'b0)) i_irq_prio_ctrl_slv (
        .clk(clk), .rst_n(rst_n), .wr_en(s_we), .rd_en(s_re), .addr(s_a),
        .wdata(s_wd), .rdata(s_rd), .irq_in(s_src), .int_out(s_int),
        .ack(ack), .cas_in(m_cas), .cas_out(s_cas), .vec_valid(s_vv), .vec_out(s_vec)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit sl, input bit a, input logic [7:0] v);
        @(negedge clk);
        if (sl) begin s_we = 1; s_a = a; s_wd = v; end
        else    begin m_we = 1; m_a = a; m_wd = v; end
        @(negedge clk);
        m_we = 0; s_we = 0;
    endtask

    task automatic rd(input bit sl, input bit a, output logic [7:0] v);
        @(negedge clk);
        if (sl) begin s_re = 1; s_a = a; end
        else    begin m_re = 1; m_a = a; end
        #1 v = sl ? s_rd : m_rd;
        @(negedge clk);
        m_re = 0; s_re = 0;
    endtask

    task automatic do_ack();
        @(negedge clk);
        ack = 1;
        #1;
        @(negedge clk);
        ack = 0;
    endtask

    logic       a_mvv, a_svv;
    logic [2:0] a_mcas;
    logic [7:0] a_mvec, a_svec;

    task automatic ack_cap();
        @(negedge clk);
        ack = 1;
        #1;
        a_mvv = m_vv; a_svv = s_vv; a_mcas = m_cas; a_mvec = m_vec; a_svec = s_vec;
        @(negedge clk);
        ack = 0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [3:0] lowest(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return 4'(i);
        return 4'd8;
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0x01 expected 0x00");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, m, r, exp_isr;
        logic [3:0] l;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(0, 1, v); chk("R1 mask after reset", v, 8'hFF);
        rd(0, 0, v); chk("R1 request reg after reset", v, 8'h00);
        chk("R1 int_out after reset", {7'd0, m_int}, 8'h00);

        // R2 init both controllers
        wr(0, 0, 8'h11); wr(0, 1, 8'h00); wr(0, 1, 8'h04); wr(0, 1, 8'h01);
        wr(1, 0, 8'h11); wr(1, 1, 8'h08); wr(1, 1, 8'h02); wr(1, 1, 8'h01);
        rd(0, 1, v); chk("R2 master mask after init", v, 8'h00);
        wr(0, 1, 8'h5A); rd(0, 1, v); chk("R2 odd write reaches mask", v, 8'h5A);
        wr(0, 1, 8'h00);

        // R5 nested priority, R9 vectors, R6 EOI
        m_src = 8'h20; settle();
        chk("R5 int on input 5", {7'd0, m_int}, 8'h01);
        ack_cap(); chk("R9 vector level 5", a_mvec, 8'h05); chk("R9 vec_valid", {7'd0, a_mvv}, 8'h01);
        m_src = 8'h60; settle();
        chk("R5 lower level blocked by in-service", {7'd0, m_int}, 8'h00);
        m_src = 8'h62; settle();
        chk("R5 higher level preempts", {7'd0, m_int}, 8'h01);
        ack_cap(); chk("R9 vector level 1", a_mvec, 8'h01);
        wr(0, 0, 8'h0B); rd(0, 0, v); chk("R7 in-service nested", v, 8'h22);
        wr(0, 0, 8'h20); rd(0, 0, v); chk("R6 EOI clears level 1", v, 8'h20);
        chk("R5 int low while 5 in service", {7'd0, m_int}, 8'h00);
        wr(0, 0, 8'h20); rd(0, 0, v); chk("R6 EOI clears level 5", v, 8'h00);
        chk("R5 level 6 now pending", {7'd0, m_int}, 8'h01);
        ack_cap(); chk("R9 vector level 6", a_mvec, 8'h06);
        wr(0, 0, 8'h20);
        m_src = 8'h00; settle();

        // R8 poll
        m_src = 8'h08; settle();
        wr(0, 0, 8'h0C); rd(0, 0, v); chk("R8 poll byte", v, 8'h83);
        rd(0, 0, v); chk("R8 poll set in-service", v, 8'h08);
        wr(0, 0, 8'h20);
        m_src = 8'h00; settle();
        wr(0, 0, 8'h0C); rd(0, 0, v); chk("R8 empty poll", v, 8'h07);
        rd(0, 0, v); chk("R8 empty poll keeps in-service", v, 8'h00);

        // R9 spurious acknowledge, R4 request drop
        m_src = 8'h10; settle();
        m_src = 8'h00; settle();
        chk("R4 request dropped with input", {7'd0, m_int}, 8'h00);
        ack_cap(); chk("R9 spurious level 7", a_mvec, 8'h07);
        rd(0, 0, v); chk("R9 spurious leaves in-service", v, 8'h00);

        // R3 mask, R7 request select
        wr(0, 1, 8'h01); rd(0, 1, v); chk("R3 mask readback", v, 8'h01);
        m_src = 8'h01; settle();
        chk("R3 masked input no int", {7'd0, m_int}, 8'h00);
        wr(0, 0, 8'h0A); rd(0, 0, v); chk("R7 request register select", v, 8'h01);
        m_src = 8'h00; settle();
        wr(0, 1, 8'h00); wr(1, 1, 8'h00);

        // R10 cascade
        s_src = 8'h08; settle();
        chk("R10 master int from slave", {7'd0, m_int}, 8'h01);
        ack_cap();
        chk("R10 master cas_out", {5'd0, a_mcas}, 8'h02);
        chk("R10 master no vector", {7'd0, a_mvv}, 8'h00);
        chk("R10 slave supplies", {7'd0, a_svv}, 8'h01);
        chk("R10 slave vector", a_svec, 8'h0B);
        wr(0, 0, 8'h0B); rd(0, 0, v); chk("R10 master in-service 2", v, 8'h04);
        wr(1, 0, 8'h0B); rd(1, 0, v); chk("R10 slave in-service 3", v, 8'h08);
        wr(1, 0, 8'h20); wr(0, 0, 8'h20);
        s_src = 8'h00; settle();
        m_src = 8'h02; settle();
        ack_cap();
        chk("R10 slave silent on other id", {7'd0, a_svv}, 8'h00);
        chk("R10 master cas_out zero", {5'd0, a_mcas}, 8'h00);
        chk("R9 master vector level 1", a_mvec, 8'h01);
        wr(0, 0, 8'h20);
        m_src = 8'h00; settle();

        // random rounds: R3 R4 R5 R9 R6
        for (int k = 0; k < 40; k++) begin
            m = 8'($urandom);
            r = 8'($urandom) & 8'hFB;
            wr(0, 1, m);
            m_src = r; settle();
            wr(0, 0, 8'h0A); rd(0, 0, v); chk("R4 random request latch", v, r);
            chk("R5 random int", {7'd0, m_int}, {7'd0, |(r & ~m)});
            l = lowest(r & ~m);
            ack_cap();
            chk("R9 random vector", a_mvec, (l == 4'd8) ? 8'h07 : {5'd0, l[2:0]});
            exp_isr = (l == 4'd8) ? 8'h00 : (8'h01 << l);
            wr(0, 0, 8'h0B); rd(0, 0, v); chk("R9 random in-service", v, exp_isr);
            if (l != 4'd8) begin
                wr(0, 0, 8'h20); rd(0, 0, v); chk("R6 random EOI", v, 8'h00);
            end
            m_src = 8'h00; settle();
            wr(0, 0, 8'h0A); rd(0, 0, v); chk("R4 random request cleared", v, 8'h00);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule